// File: doc/BRIEF.md
# Block-Count DMA Channel

This block is a single DMA channel that copies data from system memory to a peripheral. Software programs a start address, a block size in 32-bit words and a number of blocks, then sets a run bit in the control register. The channel walks memory one word at a time, forwarding each word on a valid/ready output stream. The stream marks the last word of every block so that the peripheral takes whole blocks. The remaining-block field counts down as blocks are accepted. When it reaches zero, the run bit clears and a one-cycle completion pulse is raised.

Memory reads use a request stream (valid/ready, address) and a response stream (valid/ready, data). Only one read is outstanding at a time. Both streams follow the usual rules: a transfer happens on a cycle where valid and ready are both high, and a request stays unchanged while it waits for ready. The response stream is joined straight to the output stream, so back-pressure from the peripheral reaches memory in the same cycle. The control pins (register port, completion pulse) are plain.

Top module: `dmacch_top`

## Requirements
- R1: After reset the registers at offsets 0x0, 0x4 and 0x8 read zero, no memory request or output word is valid, and the completion line is low.
- R2: Offset 0x0 holds the 32-bit address. Offset 0x4 holds the block size in words in bits 15:0 and the remaining block count in bits 31:16. Offset 0x8 keeps only bit 0 (direction), bit 9 (sync mode), bit 10 (chain mode) and bit 24 (run). Its other bits read zero, and any unmapped offset reads zero.
- R3: A write to offset 0x6 loads data bits 15:0 into the block count and leaves the block size unchanged.
- R4: A write to 0x8 with bit 24 set, while the block size and count are both nonzero, makes bit 24 read 1 from the next cycle. Memory is then requested at the address register's low 29 bits.
- R5: A transfer delivers size × count words on the output stream, in address order, with data unchanged. The output's last flag is high on the final word of each block.
- R6: A pending memory request keeps its valid and address until it is accepted. Output data passes through only when the output side is ready.
- R7: The block count read at 0x4 drops by one as each block's last word is accepted.
- R8: When the last word of the last block is accepted, bit 24 reads 0 and the completion line is high for exactly the next cycle.
- R9: A start with block count zero or block size zero issues no memory request, leaves bit 24 at 0, and pulses completion once in the cycle after the write.
- R10: While bit 24 is 1, writes to 0x0, 0x4, 0x6, and writes to 0x8 with bit 24 set, change nothing.
- R11: A write to 0x8 with bit 24 clear, made while running, aborts the transfer. Bit 24 reads 0, no further requests issue, the remaining count stays readable, and no completion pulse is raised.
- R12: The address register advances by 4 for each word accepted, so a later start continues from where the previous transfer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_off | input | 4 | Write byte offset |
| reg_wr_data | input | 32 | Write data |
| reg_rd_off | input | 4 | Read byte offset |
| reg_rd_data | output | 32 | Read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 29 | Memory byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Channel accepts read data |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Peripheral accepts word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Final word of a block |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong word index would move the last flag off block boundaries. The scoreboard catches this on the first block. A stuck or mis-stepped address register corrupts the first data word after the fault, because the bench memory returns data that is a function of the address. Errors in the count or run bit show up as a missing, early or repeated completion pulse, or a wrong readback, within one transfer. Ignored-write and abort cases are read back through the register port right after the event.

// File: rtl/dmacch_pkg.sv
package dmacch_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_e;

  localparam logic [3:0] OFF_ADDR = 4'h0;
  localparam logic [3:0] OFF_BLK  = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h6;
  localparam logic [3:0] OFF_CTRL = 4'h8;

  localparam int CTL_DIR   = 0;
  localparam int CTL_SYNC  = 9;
  localparam int CTL_CHAIN = 10;
  localparam int CTL_RUN   = 24;
endpackage

// File: rtl/dmacch_regs.sv
module dmacch_regs
  import dmacch_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 16,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_off,
  output logic [DW-1:0] rd_data,
  input  logic          adv,
  input  logic          dec,
  input  logic          finish,
  output logic [DW-1:0] madr,
  output logic [FW-1:0] blk_size,
  output logic [FW-1:0] blk_left,
  output logic          running,
  output logic          launch,
  output logic          done
);
  localparam logic [DW-1:0] STEP = DW'(4);

  logic dir_q, sync_q, chain_q;
  logic wr_ok, ctl_wr, abort, zstart;

  assign wr_ok  = wr_en && !running;
  assign ctl_wr = wr_ok && (wr_off == OFF_CTRL);
  assign abort  = wr_en && running && (wr_off == OFF_CTRL) && !wr_data[CTL_RUN];
  assign launch = ctl_wr && wr_data[CTL_RUN] && (blk_size != '0) && (blk_left != '0);
  assign zstart = ctl_wr && wr_data[CTL_RUN] && ((blk_size == '0) || (blk_left == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      madr     <= '0;
      blk_size <= '0;
      blk_left <= '0;
      dir_q    <= 1'b0;
      sync_q   <= 1'b0;
      chain_q  <= 1'b0;
      running  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish || zstart;
      if (wr_ok && wr_off == OFF_ADDR) madr <= wr_data;
      else if (adv)                    madr <= madr + STEP;
      if (wr_ok && wr_off == OFF_BLK) begin
        blk_size <= wr_data[FW-1:0];
        blk_left <= wr_data[2*FW-1:FW];
      end else if (wr_ok && wr_off == OFF_CNT) begin
        blk_left <= wr_data[FW-1:0];
      end else if (dec) begin
        blk_left <= blk_left - 1'b1;
      end
      if (ctl_wr) begin
        dir_q   <= wr_data[CTL_DIR];
        sync_q  <= wr_data[CTL_SYNC];
        chain_q <= wr_data[CTL_CHAIN];
      end
      if (launch)                running <= 1'b1;
      else if (abort || finish)  running <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_off)
      OFF_ADDR: rd_data = madr;
      OFF_BLK:  rd_data = {blk_left, blk_size};
      OFF_CTRL: begin
        rd_data[CTL_DIR]   = dir_q;
        rd_data[CTL_SYNC]  = sync_q;
        rd_data[CTL_CHAIN] = chain_q;
        rd_data[CTL_RUN]   = running;
      end
      default:  rd_data = '0;
    endcase
  end

  // R7: a running channel always has blocks left
  assert_busy_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (blk_left != '0));
  // R11: run bit only falls on completion or an abort write
  assert_run_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(finish || (wr_en && wr_off == OFF_CTRL && !wr_data[CTL_RUN])));
  // R10: address write while running has no effect
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && wr_off == OFF_ADDR && !adv) |=> $stable(madr));
endmodule

// File: rtl/dmacch_engine.sv
module dmacch_engine
  import dmacch_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 16,
  parameter int MAW = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic           launch,
  input  logic [FW-1:0]  blk_size,
  input  logic [FW-1:0]  blk_left,
  input  logic [DW-1:0]  madr,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [MAW-1:0] req_addr,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [DW-1:0]  rsp_data,
  output logic           per_valid,
  input  logic           per_ready,
  output logic [DW-1:0]  per_data,
  output logic           per_last,
  output logic           adv,
  output logic           dec,
  output logic           finish
);
  phase_e        phase;
  logic [FW-1:0] widx;
  logic          at_end, in_wait, fire;

  assign in_wait   = (phase == PH_WAIT) && running;
  assign at_end    = (widx == blk_size - 1'b1);
  assign req_valid = (phase == PH_REQ) && running;
  assign req_addr  = madr[MAW-1:0];
  assign per_valid = in_wait && rsp_valid;
  assign rsp_ready = in_wait && per_ready;
  assign per_data  = rsp_data;
  assign per_last  = at_end;
  assign fire      = in_wait && rsp_valid && per_ready;
  assign adv       = fire;
  assign dec       = fire && at_end;
  assign finish    = fire && at_end && (blk_left == FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      widx  <= '0;
    end else if (launch) begin
      phase <= PH_REQ;
      widx  <= '0;
    end else if (!running) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_REQ:  if (req_ready) phase <= PH_WAIT;
        PH_WAIT: if (fire) begin
          widx  <= at_end ? '0 : widx + 1'b1;
          phase <= (at_end && blk_left == FW'(1)) ? PH_IDLE : PH_REQ;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: a waiting request holds its address until accepted or aborted
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ((req_valid && $stable(req_addr)) || !running));
  // R5: request and output word are never offered together
  assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && per_valid));
endmodule

// File: rtl/dmacch_top.sv
module dmacch_top
  import dmacch_pkg::*;
#(
  parameter int DW  = 32,
  parameter int FW  = 16,
  parameter int OW  = 4,
  parameter int MAW = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [OW-1:0]  reg_wr_off,
  input  logic [DW-1:0]  reg_wr_data,
  input  logic [OW-1:0]  reg_rd_off,
  output logic [DW-1:0]  reg_rd_data,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [MAW-1:0] mem_req_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_last,
  output logic           xfer_done
);
  logic [DW-1:0] madr;
  logic [FW-1:0] blk_size, blk_left;
  logic running, launch, adv, dec, finish;

  dmacch_regs #(.DW(DW), .FW(FW), .OW(OW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_off(reg_wr_off), .wr_data(reg_wr_data),
    .rd_off(reg_rd_off), .rd_data(reg_rd_data),
    .adv(adv), .dec(dec), .finish(finish),
    .madr(madr), .blk_size(blk_size), .blk_left(blk_left),
    .running(running), .launch(launch), .done(xfer_done)
  );

  dmacch_engine #(.DW(DW), .FW(FW), .MAW(MAW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .running(running), .launch(launch),
    .blk_size(blk_size), .blk_left(blk_left), .madr(madr),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data),
    .per_valid(out_valid), .per_ready(out_ready), .per_data(out_data), .per_last(out_last),
    .adv(adv), .dec(dec), .finish(finish)
  );

  // R8: the cycle after completion the channel is no longer running
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !running || $past(!running));
  // R7: accepting a block's last word lowers the count or ends the run
  assert_block_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!running || blk_left == $past(blk_left) - 1'b1));
endmodule

// File: tb/dmacch_top_test.sv
module dmacch_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_wr_off = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_rd_off = '0;
  logic [31:0] reg_rd_data;
  logic        mem_req_valid, mem_rsp_ready, out_valid, out_last, xfer_done;
  logic [28:0] mem_req_addr;
  logic [31:0] out_data;
  logic        mreq_rdy = 1'b1, orw = 1'b1, gate = 1'b1, bp_mode = 1'b0;
  logic        rv = 1'b0;
  logic [31:0] rd = '0;
  logic        out_ready;
  int checks = 0, errors = 0, popped = 0, done_cnt = 0, req_cnt = 0, cyc = 0;
  logic [32:0] expq[$];
  logic        pv = 1'b0, pr = 1'b0;
  logic [28:0] pa = '0;

  assign out_ready = orw && gate;

  always #5 clk = ~clk;

  dmacch_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_off(reg_wr_off),
    .reg_wr_data(reg_wr_data), .reg_rd_off(reg_rd_off), .reg_rd_data(reg_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mreq_rdy), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(rv), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(rd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .xfer_done(xfer_done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // memory model and stall patterns
  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    if (bp_mode) begin
      mreq_rdy <= (cyc % 3) != 0;
      orw      <= ((cyc % 5) != 2) && ((cyc % 5) != 3);
    end else begin
      mreq_rdy <= 1'b1;
      orw      <= 1'b1;
    end
    if (rv && mem_rsp_ready) rv <= 1'b0;
    if (mem_req_valid && mreq_rdy) begin
      rv <= 1'b1;
      rd <= pat({3'b000, mem_req_addr});
    end
  end

  // scoreboard monitor, sampled at the falling edge
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (out_valid && out_ready) begin
        popped++;
        if (expq.size() == 0) check("R5 unexpected word", out_data, 32'hFFFF_FFFF);
        else begin
          logic [32:0] e;
          e = expq.pop_front();
          check("R5 data", out_data, e[31:0]);
          check("R5 last", {31'd0, out_last}, {31'd0, e[32]});
        end
      end
      if (xfer_done) done_cnt++;
      if (mem_req_valid) req_cnt++;
      if (pv && !pr) begin
        check("R6 hold valid", {31'd0, mem_req_valid}, 32'd1);
        check("R6 hold addr", {3'd0, mem_req_addr}, {3'd0, pa});
      end
      pv = mem_req_valid; pr = mreq_rdy; pa = mem_req_addr;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wr_off = o; reg_wr_data = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] o, output logic [31:0] d);
    @(negedge clk);
    reg_rd_off = o;
    #1 d = reg_rd_data;
  endtask

  task automatic expect_words(input logic [31:0] a, input int size, input int cnt);
    for (int i = 0; i < size * cnt; i++) begin
      logic [31:0] ad;
      ad = (a + 32'(4 * i)) & 32'h1FFF_FFFF;
      expq.push_back({((i % size) == size - 1), pat(ad)});
    end
  endtask

  task automatic wait_done(input string req);
    int d0, n;
    d0 = done_cnt; n = 0;
    while (done_cnt == d0 && n < 3000) begin
      @(posedge clk); n++;
    end
    check({req, " completion seen"}, {31'd0, done_cnt != d0}, 32'd1);
    repeat (3) @(negedge clk);
    check({req, " single pulse"}, done_cnt, d0 + 1);
  endtask

  initial begin
    logic [31:0] v;
    int d0, r0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdreg(4'h0, v); check("R1 addr", v, 0);
    rdreg(4'h4, v); check("R1 blk", v, 0);
    rdreg(4'h8, v); check("R1 ctrl", v, 0);
    check("R1 done", {31'd0, xfer_done}, 0);
    check("R1 req", {31'd0, mem_req_valid}, 0);
    check("R1 out", {31'd0, out_valid}, 0);
    // R2 layout
    wr(4'h8, 32'h00FF_FFFF); rdreg(4'h8, v); check("R2 ctrl bits", v, 32'h0000_0601);
    rdreg(4'hC, v); check("R2 unmapped", v, 0);
    wr(4'h0, 32'h8000_0100); rdreg(4'h0, v); check("R2 addr", v, 32'h8000_0100);
    wr(4'h4, 32'h0002_0003); rdreg(4'h4, v); check("R2 blk", v, 32'h0002_0003);
    // R3 count alias
    wr(4'h6, 32'hABCD_0009); rdreg(4'h4, v); check("R3 alias", v, 32'h0009_0003);
    wr(4'h6, 32'h0000_0002);
    // R4 start, R5 stream, R8 completion, R12 address advance
    expect_words(32'h8000_0100, 3, 2);
    wr(4'h8, 32'h0100_0001);
    rdreg(4'h8, v); check("R4 run bit", v, 32'h0100_0001);
    wait_done("R8 t1");
    rdreg(4'h8, v); check("R8 run cleared", v, 32'h0000_0001);
    rdreg(4'h4, v); check("R7 count zero", v, 32'h0000_0003);
    rdreg(4'h0, v); check("R12 addr t1", v, 32'h8000_0118);
    check("R5 queue empty t1", expq.size(), 0);
    // R6 back-pressure, R10 writes while busy
    bp_mode = 1'b1;
    wr(4'h4, 32'h0003_0004);
    expect_words(32'h8000_0118, 4, 3);
    wr(4'h8, 32'h0100_0200);
    wr(4'h0, 32'hDEAD_0000);
    wr(4'h4, 32'h0005_0007);
    wr(4'h6, 32'h0000_0001);
    wr(4'h8, 32'h0100_0401);
    wait_done("R8 t2");
    bp_mode = 1'b0;
    rdreg(4'h0, v); check("R10 R12 addr t2", v, 32'h8000_0148);
    rdreg(4'h4, v); check("R10 blk kept", v, 32'h0000_0004);
    rdreg(4'h8, v); check("R10 mode kept", v, 32'h0000_0200);
    check("R5 queue empty t2", expq.size(), 0);
    // R9 zero count and zero size
    wr(4'h4, 32'h0000_0004);
    d0 = done_cnt; r0 = req_cnt;
    wr(4'h8, 32'h0100_0000);
    repeat (3) @(negedge clk);
    check("R9 zero count done", done_cnt, d0 + 1);
    check("R9 zero count no req", req_cnt, r0);
    rdreg(4'h8, v); check("R9 run stays 0", v, 0);
    wr(4'h4, 32'h0003_0000);
    d0 = done_cnt; r0 = req_cnt;
    wr(4'h8, 32'h0100_0000);
    repeat (3) @(negedge clk);
    check("R9 zero size done", done_cnt, d0 + 1);
    check("R9 zero size no req", req_cnt, r0);
    // R11 abort after two blocks
    wr(4'h4, 32'h0005_0002);
    expect_words(32'h8000_0148, 2, 5);
    p0 = popped;
    wr(4'h8, 32'h0100_0000);
    while (popped - p0 < 4) @(posedge clk);
    #1 gate = 1'b0;
    d0 = done_cnt;
    wr(4'h8, 32'h0000_0000);
    r0 = req_cnt;
    repeat (6) @(negedge clk);
    check("R11 no req after abort", req_cnt, r0);
    check("R11 no done", done_cnt, d0);
    rdreg(4'h8, v); check("R11 run cleared", v, 0);
    rdreg(4'h4, v); check("R7 R11 count left", v, 32'h0003_0002);
    rdreg(4'h0, v); check("R12 addr after abort", v, 32'h8000_0158);
    expq.delete();
    gate = 1'b1;
    // R12 continue after abort
    wr(4'h4, 32'h0001_0002);
    expect_words(32'h8000_0158, 2, 1);
    wr(4'h8, 32'h0100_0000);
    wait_done("R8 t3");
    rdreg(4'h0, v); check("R12 addr t3", v, 32'h8000_0160);
    check("R5 queue empty t3", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule